// File: doc/BRIEF.md
# Read-Block Request Frame Builder

This block streams out a complete read-block request frame for a contactless card link. A start strobe captures an 8-byte card identifier, a service code and a short list of block numbers. The block then emits the frame one byte per clock: two sync bytes, a length byte, the command byte, the identifier, a one-entry service list, the block list and a 16-bit CRC. Each block number is written in a short two-byte form when it fits in eight bits, and in a three-byte form otherwise. The length byte therefore depends on the mix of block numbers. It is worked out from the inputs at start, so the stream never has to stall or be rewritten.

A downstream serializer takes `out_byte` in every cycle where `out_valid` is high. A one-cycle `done` pulse follows the last CRC byte. A bad block count produces a one-cycle `err` pulse and no bytes at all.

Top module: `rdblk_req_builder`

## Requirements
- R1: After reset `out_valid`, `done` and `err` are low, and no byte is emitted until a start is accepted.
- R2: A start with a block count of 1 to 4 makes `out_valid` rise in the next cycle. The block then emits one byte per cycle with no gaps, and the first two bytes are 0xB2 and 0x4D.
- R3: Byte 2 holds the length, which is the number of bytes before the CRC minus 2. Byte 3 is the command code 0x06. The frame is length+4 bytes long in total.
- R4: Bytes 4 to 11 carry the identifier, most significant byte first (`card_id[63:56]` is byte 4).
- R5: Bytes 12 to 15 are 0x01 (service count), the service code low byte, the service code high byte, and the block count.
- R6: A block number below 256 is encoded as 0x80 followed by its low byte.
- R7: A block number of 256 or more is encoded as 0x00, its high byte, then its low byte.
- R8: The last two bytes are a CRC with polynomial 0x1021 and initial value 0. It covers the length byte through the last block byte and is sent high byte first.
- R9: `done` is high for exactly one cycle: the first cycle after the last CRC byte, with `out_valid` low.
- R10: A start with a block count of 0 or more than 4 raises `err` for one cycle in the next cycle, and no byte is emitted.
- R11: A start while a frame is being emitted is ignored. The frame in progress is unchanged, and no second frame follows it.
- R12: Only the first `blk_count` entries of `blk_list` are used. Entry i sits at `blk_list[16*i +: 16]`, and unused entries do not change length or content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the inputs and begin a frame |
| card_id | input | 64 | Card identifier, byte 4 of the frame in bits 63:56 |
| blk_count | input | 3 | Number of block entries, valid range 1 to 4 |
| blk_list | input | 64 | Four 16-bit block numbers, entry i at bits 16*i+15:16*i |
| svc_code | input | 16 | Service code |
| out_valid | output | 1 | out_byte holds a frame byte this cycle |
| out_byte | output | 8 | Current frame byte |
| done | output | 1 | One-cycle pulse after the last CRC byte |
| err | output | 1 | One-cycle pulse for a rejected block count |

## Verification
The frame check compares each byte against a model built from the requirements, using six input sets. These are a single short block, four short blocks including the edge values 0x00 and 0xFF, two long blocks, an alternating short/long mix with 0x0100 and 0xFFFF, and sets where unused list entries hold large values. Together they separate errors in the short/long boundary at 256, in the sum of entry sizes in the length byte, and in high/low byte order. Counts 0, 5 and 7 exercise rejection. A start pulse with different inputs, given midway through a frame, shows whether the inputs stay captured and whether a stray start is dropped.

// File: rtl/rdblk_req_builder.sv
module rdblk_req_builder #(
  parameter logic [7:0]  SYNC_HI  = 8'hB2,
  parameter logic [7:0]  SYNC_LO  = 8'h4D,
  parameter logic [7:0]  CMD      = 8'h06,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter int          MAX_BLK  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] card_id,
  input  logic [2:0]  blk_count,
  input  logic [63:0] blk_list,
  input  logic [15:0] svc_code,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  output logic        done,
  output logic        err
);
  localparam logic [7:0] FIXED_LEN = 8'd14;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_BLK, S_CRC} st_t;

  st_t         st;
  logic [3:0]  pos;
  logic [1:0]  bi, sub;
  logic [15:0] crc_q;
  logic [63:0] id_q, blk_q;
  logic [15:0] svc_q;
  logic [2:0]  cnt_q;
  logic [7:0]  len_q, len_in, hdr_byte, blk_byte;
  logic [15:0] cur_blk;
  logic [2:0]  k;
  logic        big, crc_upd;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ({r[14:0], 1'b0} ^ CRC_POLY) : {r[14:0], 1'b0};
    return r;
  endfunction

  wire cnt_ok = (blk_count != 3'd0) && (blk_count <= 3'(MAX_BLK));

  always_comb begin
    len_in = FIXED_LEN;
    for (int i = 0; i < MAX_BLK; i++)
      if (3'(i) < blk_count)
        len_in = len_in + ((blk_list[16*i +: 16] > 16'd255) ? 8'd3 : 8'd2);
  end

  assign k       = pos[2:0] - 3'd4;
  assign cur_blk = blk_q[{bi, 4'b0000} +: 16];
  assign big     = |cur_blk[15:8];

  always_comb begin
    case (pos)
      4'd0:    hdr_byte = SYNC_HI;
      4'd1:    hdr_byte = SYNC_LO;
      4'd2:    hdr_byte = len_q;
      4'd3:    hdr_byte = CMD;
      4'd12:   hdr_byte = 8'h01;
      4'd13:   hdr_byte = svc_q[7:0];
      4'd14:   hdr_byte = svc_q[15:8];
      4'd15:   hdr_byte = {5'd0, cnt_q};
      default: hdr_byte = id_q[{~k, 3'b000} +: 8];
    endcase
  end

  assign blk_byte = (sub == 2'd0) ? (big ? 8'h00 : 8'h80)
                  : (sub == 2'd1 && big) ? cur_blk[15:8] : cur_blk[7:0];

  assign out_valid = (st != S_IDLE);
  assign out_byte  = (st == S_HDR) ? hdr_byte
                   : (st == S_BLK) ? blk_byte
                   : (st == S_CRC) ? (pos[0] ? crc_q[7:0] : crc_q[15:8]) : 8'h00;
  assign crc_upd   = (st == S_HDR && pos >= 4'd2) || st == S_BLK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pos <= '0; bi <= '0; sub <= '0; crc_q <= '0;
      id_q <= '0; blk_q <= '0; svc_q <= '0; cnt_q <= '0; len_q <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (crc_upd) crc_q <= crc_step(crc_q, out_byte);
      case (st)
        S_IDLE: if (start) begin
          if (cnt_ok) begin
            st <= S_HDR; pos <= '0; crc_q <= '0;
            id_q <= card_id; blk_q <= blk_list; svc_q <= svc_code;
            cnt_q <= blk_count; len_q <= len_in;
          end else err <= 1'b1;
        end
        S_HDR: if (pos == 4'd15) begin
          st <= S_BLK; bi <= '0; sub <= '0;
        end else pos <= pos + 4'd1;
        S_BLK: if (sub == (big ? 2'd2 : 2'd1)) begin
          sub <= '0;
          if ({1'b0, bi} == cnt_q - 3'd1) begin
            st <= S_CRC; pos <= '0;
          end else bi <= bi + 2'd1;
        end else sub <= sub + 2'd1;
        S_CRC: if (pos[0]) begin
          st <= S_IDLE; done <= 1'b1;
        end else pos <= 4'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [5:0] n_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) n_seen <= '0;
    else        n_seen <= out_valid ? n_seen + 6'd1 : 6'd0;
  end

  assert_sync_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_byte == SYNC_HI);
  assert_sync_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> (out_valid && out_byte == SYNC_LO));
  assert_frame_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({2'b00, n_seen} == len_q + 8'd4));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !err));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_no_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!out_valid && !err));
endmodule

// File: tb/rdblk_req_builder_bench.sv
`timescale 1ns/1ps
module rdblk_req_builder_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] card_id = '0, blk_list = '0;
  logic [2:0]  blk_count = '0;
  logic [15:0] svc_code = '0;
  logic        out_valid, done, err;
  logic [7:0]  out_byte;

  always #2.5 clk = ~clk;

  rdblk_req_builder u_rdblk_req_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .card_id(card_id),
    .blk_count(blk_count), .blk_list(blk_list), .svc_code(svc_code),
    .out_valid(out_valid), .out_byte(out_byte), .done(done), .err(err));

  // {count, blocks b3..b0, service, identifier}
  localparam int NV = 6;
  localparam logic [146:0] VEC [NV] = '{
    {3'd1, 64'h0000_0000_0000_0005, 16'h000B, 64'h0102030405060708},
    {3'd4, 64'h0083_0002_00FF_0000, 16'h0009, 64'h1122334455667788},
    {3'd2, 64'h0000_0000_1234_0100, 16'hABCD, 64'hFEDCBA9876543210},
    {3'd4, 64'hFFFF_0001_0100_00FF, 16'h8000, 64'hA5A55A5A0F0FF0F0},
    {3'd3, 64'h9999_0003_0080_0200, 16'h0102, 64'h0000000000000001},
    {3'd1, 64'hFFFF_EEEE_DDDD_0100, 16'h7F7F, 64'h8000000000000000}
  };

  int total = 0, bad = 0;
  logic [7:0] exp_f [40];
  string      exp_tag [40];
  int         exp_n;
  logic [7:0] got [40];
  int         got_n;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic build(input logic [146:0] v);
    logic [2:0]  cnt = v[146:144];
    logic [63:0] bl  = v[143:80];
    logic [15:0] sv  = v[79:64];
    logic [63:0] id  = v[63:0];
    logic [15:0] b, crc;
    int n = 0;
    exp_f[n] = 8'hB2; exp_tag[n] = "R2"; n++;
    exp_f[n] = 8'h4D; exp_tag[n] = "R2"; n++;
    n++;
    exp_f[n] = 8'h06; exp_tag[n] = "R3"; n++;
    for (int i = 0; i < 8; i++) begin exp_f[n] = id[63-8*i -: 8]; exp_tag[n] = "R4"; n++; end
    exp_f[n] = 8'h01; exp_tag[n] = "R5"; n++;
    exp_f[n] = sv[7:0]; exp_tag[n] = "R5"; n++;
    exp_f[n] = sv[15:8]; exp_tag[n] = "R5"; n++;
    exp_f[n] = {5'd0, cnt}; exp_tag[n] = "R5"; n++;
    for (int i = 0; i < int'(cnt); i++) begin
      b = bl[16*i +: 16];
      if (b < 16'd256) begin
        exp_f[n] = 8'h80; exp_tag[n] = "R6"; n++;
        exp_f[n] = b[7:0]; exp_tag[n] = "R6"; n++;
      end else begin
        exp_f[n] = 8'h00; exp_tag[n] = "R7"; n++;
        exp_f[n] = b[15:8]; exp_tag[n] = "R7"; n++;
        exp_f[n] = b[7:0]; exp_tag[n] = "R7"; n++;
      end
    end
    exp_f[2] = 8'(n - 2); exp_tag[2] = "R3";
    crc = 16'h0000;
    for (int i = 2; i < n; i++) crc = crc_byte(crc, exp_f[i]);
    exp_f[n] = crc[15:8]; exp_tag[n] = "R8"; n++;
    exp_f[n] = crc[7:0];  exp_tag[n] = "R8"; n++;
    exp_n = n;
  endtask

  task automatic run(input logic [146:0] v, input bit mid_start, input logic [146:0] alt);
    build(v);
    @(negedge clk);
    {blk_count, blk_list, svc_code, card_id} = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_n = 0;
    chk(out_valid == 1'b1, "R2", "valid after start", int'(out_valid), 1);
    for (int s = 0; s < 40; s++) begin
      if (s > 0) @(negedge clk);
      start = 1'b0;
      if (!out_valid) break;
      got[got_n] = out_byte;
      got_n++;
      if (mid_start && s == 5) begin
        {blk_count, blk_list, svc_code, card_id} = alt;
        start = 1'b1;
      end
    end
    chk(got_n == exp_n, "R3", "frame length", got_n, exp_n);
    chk(got_n == exp_n, "R12", "entries used", got_n, exp_n);
    for (int j = 0; j < exp_n && j < got_n; j++)
      chk(got[j] == exp_f[j], exp_tag[j], $sformatf("byte %0d", j), int'(got[j]), int'(exp_f[j]));
    chk(done == 1'b1, "R9", "done after last byte", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", int'(done), 0);
  endtask

  task automatic bad_count(input logic [2:0] c);
    @(negedge clk);
    blk_count = c; blk_list = 64'h0001_0002_0003_0004; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && out_valid == 1'b0, "R10", $sformatf("err for count %0d", c), int'({err, out_valid}), 2);
    @(negedge clk);
    chk(err == 1'b0 && out_valid == 1'b0, "R10", "no frame after err", int'({err, out_valid}), 0);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "in reset",
        int'({out_valid, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "after reset",
        int'({out_valid, done, err}), 0);

    for (int vi = 0; vi < NV; vi++) run(VEC[vi], 1'b0, VEC[0]);

    bad_count(3'd0);
    bad_count(3'd5);
    bad_count(3'd7);

    // R11: stray start mid-frame with other inputs
    run(VEC[1], 1'b1, VEC[2]);
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "no second frame", int'(out_valid), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule